// File: doc/BRIEF.md
# Pseudo-Random Self-Test Engine with Serial Signature Check

This block tests a small combinational circuit on the chip without outside stimulus. A start pulse seeds a maximal-length pattern generator and clears a serial signature register. The generator steps through every nonzero state of its register, and each state drives the circuit under test. On every step the circuit's response word is folded to one parity bit, and that bit is shifted into the signature register. After the last pattern, the final signature is compared with a golden value given as a parameter. The block then reports pass or fail and holds that verdict until the next start.

The circuit under test is built into the wrapper, so any of its nets can be forced to a stuck level from outside. This shows that a single stuck-at defect changes the compacted response. In normal use the fault inputs are tied inactive. The golden signature is worked out once from a fault-free model and passed in as a parameter.

Top module: `bist_engine`

## Requirements
- R1: While reset is asserted and until the first start, busy, done, pass and fail are 0 and the signature is all zeros.
- R2: A start sampled high while idle makes busy rise on the next clock edge. Busy then stays high for exactly 2^W - 1 cycles, where W is the generator width (8 by default, so 255 cycles).
- R3: Done is a one-cycle pulse. It is raised on the same edge that drops busy and is low again on the following edge.
- R4: With no fault forced, a run ends with pass = 1, fail = 0 and a signature equal to the golden parameter.
- R5: After done, pass and fail keep their values until the next accepted start. That start clears both to 0 on its edge.
- R6: A start that arrives while busy is high is ignored: the run length and the final signature do not change.
- R7: The generator is a left-shifting register seeded with 0x01 on start. Its feedback is the XOR of bits 7, 5, 4 and 3 (tap mask 0xB8), and that feedback enters at bit 0. It never holds zero, and after the run it is back at its seed. One pattern is applied per busy cycle, beginning with the seed.
- R8: The response bit for each pattern is the XOR of all circuit outputs. Output j is p[j] XOR (x[(j+1) mod W] OR x[(j+3) mod W]), with product p[j] = x[j] AND x[(j+4) mod W] and x being the pattern. The 16-bit signature starts at 0 and shifts left. Its new bit 0 is the response bit XOR the signature bits 15, 13, 12 and 10 (mask 0xB400).
- R9: With fault enable high, net index k is forced to the fault value. Indices 0..7 are pattern bits x[k], and indices 8..11 are products p[k-8]. The signature then follows the faulted circuit. Fail is 1 exactly when that signature differs from the golden value, and a stuck level on x[0] is always flagged.
- R10: Pass and fail are never high together, and exactly one of them is high in the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a self-test run when idle |
| flt_en | input | 1 | Enables the forced stuck-at net |
| flt_sel | input | 4 | Index of the net to force |
| flt_val | input | 1 | Stuck level, 0 or 1 |
| busy | output | 1 | High while patterns are being applied |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Final signature matched the golden value |
| fail | output | 1 | Final signature differed from the golden value |
| signature | output | 16 | Contents of the signature register |

## Verification
The hardest situation to reach from the ports is a defect deep inside the circuit under test. Such a defect is visible only through a 16-bit signature built up over 255 parity bits. The stimulus forces stuck levels on pattern bits and on internal product nets through the fault inputs. It then compares the whole signature with an independent bit-level model of the faulted circuit, so both missed and false detections show up. A second hard case is a start that arrives in the middle of a run. The bench pulses start while busy and checks that the run length and the signature stay unchanged.

// File: rtl/bist_pkg.sv
package bist_pkg;

  localparam int unsigned GEN_W   = 8;
  localparam int unsigned RESP_W  = 4;
  localparam int unsigned SIG_W   = 16;
  localparam logic [GEN_W-1:0] GEN_TAPS = 8'hB8;
  localparam logic [GEN_W-1:0] GEN_SEED = 8'h01;
  localparam logic [SIG_W-1:0] SIG_TAPS = 16'hB400;

  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

  // Parity of the fault-free circuit response for one pattern (default widths).
  function automatic logic resp_parity(input logic [GEN_W-1:0] x);
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < int'(RESP_W); j++) begin
      acc = acc ^ ((x[j] & x[(j + int'(RESP_W)) % int'(GEN_W)]) ^
                   (x[(j + 1) % int'(GEN_W)] | x[(j + 3) % int'(GEN_W)]));
    end
    return acc;
  endfunction

  // Golden signature for the default configuration.
  function automatic logic [SIG_W-1:0] golden_sig();
    logic [GEN_W-1:0] g;
    logic [SIG_W-1:0] s;
    g = GEN_SEED;
    s = '0;
    for (int i = 0; i < (1 << GEN_W) - 1; i++) begin
      s = {s[SIG_W-2:0], resp_parity(g) ^ (^(s & SIG_TAPS))};
      g = {g[GEN_W-2:0], ^(g & GEN_TAPS)};
    end
    return s;
  endfunction

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
  parameter int unsigned      W    = 8,
  parameter logic [W-1:0]     TAPS = 8'hB8,
  parameter logic [W-1:0]     SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] vec_o
);

  logic [W-1:0] vec_q, vec_d;
  logic         fb;

  always_comb begin
    fb    = ^(vec_q & TAPS);
    vec_d = vec_q;
    if (load_i)      vec_d = SEED;
    else if (step_i) vec_d = {vec_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= SEED;
    else        vec_q <= vec_d;
  end

  assign vec_o = vec_q;

  // R7: the generator never enters the all-zero lock-up state
  p_gen_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q != '0);

  // R7: a step always moves the register (no fixed point on nonzero states)
  p_gen_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && vec_q != {W{1'b1}}) |=> !$stable(vec_q));

endmodule

// File: rtl/bist_cut.sv
module bist_cut #(
  parameter int unsigned W  = 8,
  parameter int unsigned M  = 4,
  parameter int unsigned KW = 4
) (
  input  logic [W-1:0]  vec_i,
  input  logic          flt_en_i,
  input  logic [KW-1:0] flt_sel_i,
  input  logic          flt_val_i,
  output logic [M-1:0]  resp_o
);

  logic [W-1:0] x;
  logic [M-1:0] prod_raw, prod;

  for (genvar gi = 0; gi < int'(W); gi++) begin : g_in
    assign x[gi] = (flt_en_i && flt_sel_i == KW'(gi)) ? flt_val_i : vec_i[gi];
  end

  for (genvar gj = 0; gj < int'(M); gj++) begin : g_out
    assign prod_raw[gj] = x[gj] & x[(gj + int'(M)) % int'(W)];
    assign prod[gj]     = (flt_en_i && flt_sel_i == KW'(int'(W) + gj)) ? flt_val_i
                                                                        : prod_raw[gj];
    assign resp_o[gj]   = prod[gj] ^ (x[(gj + 1) % int'(W)] | x[(gj + 3) % int'(W)]);
  end

endmodule

// File: rtl/bist_sig_reg.sv
module bist_sig_reg #(
  parameter int unsigned  S    = 16,
  parameter logic [S-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [S-1:0] sig_d_o,
  output logic [S-1:0] sig_o
);

  logic [S-1:0] sig_q, sig_d;

  always_comb begin
    sig_d = sig_q;
    if (load_i)      sig_d = '0;
    else if (step_i) sig_d = {sig_q[S-2:0], bit_i ^ (^(sig_q & TAPS))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign sig_o   = sig_q;
  assign sig_d_o = sig_d;

  // R8: an idle register (no load, no step) holds its signature
  p_sig_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(sig_q));

  // R5: a load clears the signature on the next edge
  p_sig_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sig_q == '0));

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int unsigned PAT = 255,
  parameter int unsigned CW  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic match_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o,
  output logic pass_o,
  output logic fail_o
);

  run_state_e     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d, pass_q, pass_d, fail_q, fail_d;
  logic           load, step, last;

  always_comb begin
    load   = (st_q == ST_IDLE) && start_i;
    step   = (st_q == ST_RUN);
    last   = step && (cnt_q == CW'(PAT - 1));
    st_d   = st_q;
    cnt_d  = cnt_q;
    pass_d = pass_q;
    fail_d = fail_q;
    done_d = last;
    if (load) begin
      st_d   = ST_RUN;
      cnt_d  = '0;
      pass_d = 1'b0;
      fail_d = 1'b0;
    end else if (last) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      pass_d = match_i;
      fail_d = !match_i;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  assign load_o = load;
  assign step_o = step;
  assign busy_o = (st_q == ST_RUN);
  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;

  // R2: the pattern count stays inside the run length while busy
  p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (cnt_q < CW'(PAT)));

  // R3: done lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3: done only appears as busy falls
  p_done_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(st_q == ST_RUN));

  // R10: verdict outputs are exclusive, and one is set at done
  p_verdict_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q));
  p_verdict_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pass_q || fail_q));

  // R5: verdict holds while idle and no start arrives
  p_verdict_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> ($stable(pass_q) && $stable(fail_q)));

  // R6: a start while running does not restart the count
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && start_i && cnt_q != CW'(PAT - 1)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter int unsigned         W        = GEN_W,
  parameter int unsigned         M        = RESP_W,
  parameter int unsigned         S        = SIG_W,
  parameter logic [W-1:0]        G_TAPS   = GEN_TAPS,
  parameter logic [W-1:0]        G_SEED   = GEN_SEED,
  parameter logic [S-1:0]        S_TAPS   = SIG_TAPS,
  parameter logic [S-1:0]        EXP_SIG  = golden_sig(),
  localparam int unsigned        NETS     = W + M,
  localparam int unsigned        KW       = $clog2(NETS),
  localparam int unsigned        PAT      = (1 << W) - 1,
  localparam int unsigned        CW       = $clog2(PAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          flt_en,
  input  logic [KW-1:0] flt_sel,
  input  logic          flt_val,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [S-1:0]  signature
);

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic         load, step, resp_bit, match;
  logic [W-1:0] vec;
  logic [M-1:0] resp;
  logic [S-1:0] sig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bist_ctrl #(.PAT(PAT), .CW(CW)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start_i(start),
    .match_i(match),
    .load_o (load),
    .step_o (step),
    .busy_o (busy),
    .done_o (done),
    .pass_o (pass),
    .fail_o (fail)
  );

  bist_pattern_gen #(.W(W), .TAPS(G_TAPS), .SEED(G_SEED)) i_gen (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load_i(load),
    .step_i(step),
    .vec_o (vec)
  );

  bist_cut #(.W(W), .M(M), .KW(KW)) i_cut (
    .vec_i    (vec),
    .flt_en_i (flt_en),
    .flt_sel_i(flt_sel),
    .flt_val_i(flt_val),
    .resp_o   (resp)
  );

  assign resp_bit = ^resp;

  bist_sig_reg #(.S(S), .TAPS(S_TAPS)) i_sig (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .step_i (step),
    .bit_i  (resp_bit),
    .sig_d_o(sig_d),
    .sig_o  (signature)
  );

  assign match = (sig_d == EXP_SIG);

  // R7: after a full run the generator has wrapped back to its seed
  p_gen_wrap_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (vec == G_SEED));

  // R9: verdict agrees with the final signature
  p_verdict_sig_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (pass == (signature == EXP_SIG)));

endmodule

// File: tb/test_bist_engine.sv
module test_bist_engine;

  localparam int unsigned W  = 8;
  localparam int unsigned KW = 4;
  localparam int unsigned RUN_LEN = 255;

  // Independent bit-level model of the self-test (requirements R7, R8, R9).
  function automatic logic [15:0] model_sig(input logic en, input logic [3:0] k,
                                            input logic v);
    logic [7:0]  g;
    logic [15:0] s;
    logic [7:0]  x;
    logic [3:0]  p;
    logic        b;
    g = 8'h01;
    s = 16'h0000;
    for (int n = 0; n < 255; n++) begin
      x = g;
      if (en && k < 4'd8) x[k[2:0]] = v;
      b = 1'b0;
      for (int j = 0; j < 4; j++) begin
        p[j] = x[j] & x[(j + 4) % 8];
        if (en && k == 4'(8 + j)) p[j] = v;
        b = b ^ p[j] ^ (x[(j + 1) % 8] | x[(j + 3) % 8]);
      end
      s = {s[14:0], b ^ s[15] ^ s[13] ^ s[12] ^ s[10]};
      g = {g[6:0], g[7] ^ g[5] ^ g[4] ^ g[3]};
    end
    return s;
  endfunction

  localparam logic [15:0] GOLD = model_sig(1'b0, 4'd0, 1'b0);

  // Fault table: {enable, net index, stuck value}
  localparam logic [5:0] VEC [0:7] = '{
    {1'b0, 4'd0,  1'b0},
    {1'b1, 4'd0,  1'b0},
    {1'b1, 4'd0,  1'b1},
    {1'b1, 4'd5,  1'b1},
    {1'b1, 4'd8,  1'b0},
    {1'b1, 4'd11, 1'b1},
    {1'b1, 4'd3,  1'b0},
    {1'b1, 4'd9,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n, start, flt_en, flt_val;
  logic [KW-1:0] flt_sel;
  logic          busy, done, pass, fail;
  logic [15:0]   signature;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  bist_engine #(.EXP_SIG(GOLD)) i_bist_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .flt_en   (flt_en),
    .flt_sel  (flt_sel),
    .flt_val  (flt_val),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .fail     (fail),
    .signature(signature)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Pulse start; optionally pulse start again mid-run; measure the run.
  task automatic run_bist(input logic en, input logic [3:0] k, input logic v,
                          input bit restart, input string tag);
    int         len;
    logic [15:0] exp_sig;
    exp_sig = model_sig(en, k, v);
    flt_en = en; flt_sel = k; flt_val = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1 && pass == 1'b0 && fail == 1'b0,
        {"R2/R5 busy after start ", tag}, {busy, pass, fail}, 3'b100);
    len = 1;
    while (busy && len < 1000) begin
      if (restart && len == 100) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (busy) len++;
    end
    chk(len == RUN_LEN, {"R2/R6 run length ", tag}, len, RUN_LEN);
    chk(done == 1'b1, {"R3 done at end ", tag}, done, 1);
    chk(signature == exp_sig, {"R8/R9 signature ", tag}, signature, exp_sig);
    chk(pass == (exp_sig == GOLD) && fail == (exp_sig != GOLD),
        {"R9/R10 verdict ", tag}, {pass, fail}, {exp_sig == GOLD, exp_sig != GOLD});
    @(negedge clk);
    chk(done == 1'b0, {"R3 done one cycle ", tag}, done, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; flt_en = 1'b0; flt_sel = '0; flt_val = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, pass, fail} == 4'b0 && signature == 16'h0,
        "R1 reset state", {busy, done, pass, fail, signature}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, pass, fail} == 4'b0 && signature == 16'h0,
        "R1 idle after reset", {busy, done, pass, fail, signature}, 0);

    for (int i = 0; i < 8; i++) begin
      run_bist(VEC[i][5], VEC[i][4:1], VEC[i][0], 1'b0, $sformatf("vec%0d", i));
    end

    // R4: fault-free run passes with the golden signature
    run_bist(1'b0, 4'd0, 1'b0, 1'b0, "R4 clean");
    chk(pass == 1'b1 && signature == GOLD, "R4 clean pass", {pass, signature}, {1'b1, GOLD});

    // R5: verdict holds while idle
    repeat (20) @(negedge clk);
    chk(pass == 1'b1 && fail == 1'b0, "R5 verdict held", {pass, fail}, 2'b10);

    // R9: stuck x[0] is always flagged
    run_bist(1'b1, 4'd0, 1'b1, 1'b0, "R9 stuck x0");
    chk(fail == 1'b1 && pass == 1'b0, "R9 x0 flagged", {pass, fail}, 2'b01);
    repeat (10) @(negedge clk);
    chk(fail == 1'b1, "R5 fail held", fail, 1);

    // R6: start pulse during a run is ignored
    run_bist(1'b0, 4'd0, 1'b0, 1'b1, "R6 restart ignored");
    chk(signature == GOLD, "R6 signature unchanged", signature, GOLD);

    // R1/R5: reset mid-run clears everything
    flt_en = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy, done, pass, fail} == 4'b0 && signature == 16'h0,
        "R1 reset mid-run", {busy, done, pass, fail, signature}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule